// File: doc/BRIEF.md
# Asymmetric Programmable SPI Clock Divider

This block derives the SPI serial clock, plus two single-cycle timing strobes, from the parent clock. The SCK period and the length of the active phase are set by separate 6-bit fields of one 32-bit clock-configuration word. The duty cycle is therefore programmed directly and is not fixed at one half. A transfer engine holds `run` high for as long as it wants clock pulses. When `run` drops, the divider finishes the period it is in and then parks SCK at the idle level selected by `idle_high`.

The strobes mark the two SCK transitions. `capture` is high for the parent-clock cycle in which SCK enters its active level, which is the sampling edge for clock-phase-zero transfers. `launch` is high for the cycle in which SCK returns to idle, which is where the next bit is shifted out. A new configuration word can be written at any time. It takes effect at once while the divider is idle. While the divider is running, the word is held until the next period boundary. The clock-source select bit is only stored and brought out.

Software picks a divide value n of 1 or more and writes n to the divider field, n to the low-count field and (n+1)/2-1 to the high-count field. This gives an SCK period of n+1 parent clocks.

Top module: `spi_sck_divider`

## Requirements
- R1: After reset, `sck`, `launch`, `capture` and `src_sel` are 0, and the live configuration is period limit 1 with high count 0, so a run without any write gives a 2-clock period with 1 active clock.
- R2: The period limit W is taken from the low-count field, `cfg_data[5:0]`, when that field is nonzero. Otherwise it is taken from the divider field, `cfg_data[17:12]`, when that field is nonzero. Otherwise W is 1. One SCK period lasts W+1 parent clocks.
- R3: The active phase is the first min(Hc, W-1)+1 clocks of every period, where Hc is the high-count field `cfg_data[11:6]`. The remaining clocks of the period are inactive, so every period has at least one inactive clock.
- R4: While the divider is idle, `sck` equals the `idle_high` value sampled one clock earlier. The active level of `sck` is the inverse of the idle level.
- R5: `capture` is high for exactly the first clock of each period, in which `sck` is at its active level. `launch` is high for exactly the first inactive clock of each period. The two are never high together.
- R6: When `run` is sampled high at a clock edge while the divider is idle, `sck` is at its active level in the cycle that follows.
- R7: When `run` is sampled low, the current period runs to its end. After the end of that period `sck` rests at idle and no strobe fires.
- R8: A write (`cfg_wr` high) while idle, or in the last clock of a period, applies from the next clock. A write made in any other clock of a running period applies from the first clock of the next period.
- R9: Bit 31 of the written word is presented on `src_sel` with the same timing as R8.
- R10: A change of `idle_high` while a transfer runs does not alter `sck` until the transfer has ended.
- R11: Bits 30:18 of the written word have no effect on `sck`, the strobes or `src_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_data | input | 32 | Configuration word: source bit 31, divider 17:12, high count 11:6, low count 5:0 |
| run | input | 1 | Clock request from the transfer engine |
| idle_high | input | 1 | Idle SCK level (1 = idle high) |
| sck | output | 1 | Serial clock |
| launch | output | 1 | One-clock strobe on each return of SCK to idle |
| capture | output | 1 | One-clock strobe on each entry of SCK into the active level |
| src_sel | output | 1 | Stored clock-source select bit |

## Verification
The bench programs a high count of 63 against a short period. A design that skips the clamp would hold SCK active for the whole period, and `launch` would never fire. It also programs a zero low count and an all-zero word. A design that gets the fallback wrong would count through 64 clocks, or stall, instead of giving the expected short period. Mid-period writes, and writes landing on the last clock of a period, are checked against the exact cycle where the new period and `src_sel` appear; an early apply would leave a truncated pulse and a late one would stretch a period. Flipping `idle_high` in the middle of a run, and dropping `run` in the middle of a period, show whether SCK glitches or gets cut short before it parks.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  localparam int REG_W   = 32;
  localparam int FW      = 6;
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = LO_LSB + FW;
  localparam int DIV_LSB = HI_LSB + FW;
  localparam int SRC_BIT = REG_W - 1;
  localparam int RSV_LSB = DIV_LSB + FW;
  localparam int RSV_MSB = SRC_BIT - 1;

  typedef logic [FW-1:0] fld_t;

  typedef struct packed {
    logic src;
    fld_t div;
    fld_t hi;
    fld_t lo;
  } clkcfg_t;

  localparam clkcfg_t CFG_RST = '{src: 1'b0, div: fld_t'(1), hi: fld_t'(0), lo: fld_t'(1)};

  // Split a configuration word into its fields.
  function automatic clkcfg_t cfg_unpack(input logic [REG_W-1:0] w);
    clkcfg_t c;
    c.src = w[SRC_BIT];
    c.div = w[DIV_LSB +: FW];
    c.hi  = w[HI_LSB +: FW];
    c.lo  = w[LO_LSB +: FW];
    return c;
  endfunction

  // Last counter value of a period: low count, else divider, else 1.
  function automatic fld_t wrap_of(input clkcfg_t c);
    if (c.lo != '0)       return c.lo;
    else if (c.div != '0) return c.div;
    else                  return fld_t'(1);
  endfunction

  // Last active counter value, kept below the wrap point.
  function automatic fld_t hi_of(input clkcfg_t c, input fld_t w);
    return (c.hi >= w) ? (w - fld_t'(1)) : c.hi;
  endfunction
endpackage

// File: rtl/sckdiv_cfg_shadow.sv
module sckdiv_cfg_shadow
  import sckdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  clkcfg_t wr_cfg,
  input  logic    open_win,
  output clkcfg_t live
);
  clkcfg_t pend_q;
  logic    pend_vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live       <= CFG_RST;
      pend_q     <= CFG_RST;
      pend_vld_q <= 1'b0;
    end else if (wr_en && open_win) begin
      live       <= wr_cfg;
      pend_vld_q <= 1'b0;
    end else if (wr_en) begin
      pend_q     <= wr_cfg;
      pend_vld_q <= 1'b1;
    end else if (open_win && pend_vld_q) begin
      live       <= pend_q;
      pend_vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sckdiv_phase_cnt.sv
module sckdiv_phase_cnt
  import sckdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  fld_t wrap,
  input  fld_t hi,
  output logic act_q,
  output logic at_wrap,
  output logic ph_next
);
  fld_t cnt_q, cnt_n;
  logic act_n;

  assign at_wrap = act_q && (cnt_q == wrap);

  always_comb begin
    if (!act_q || at_wrap) begin
      act_n = run;
      cnt_n = '0;
    end else begin
      act_n = 1'b1;
      cnt_n = cnt_q + fld_t'(1);
    end
    ph_next = act_n && (cnt_n <= hi);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/sckdiv_edge_gen.sv
module sckdiv_edge_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic ph_next,
  input  logic idle_high,
  output logic sck,
  output logic launch,
  output logic capture
);
  logic ph_q, pol_q, pol_n;

  // Idle level is only sampled while no transfer runs.
  assign pol_n = act ? pol_q : idle_high;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= 1'b0;
      pol_q   <= 1'b0;
      sck     <= 1'b0;
      launch  <= 1'b0;
      capture <= 1'b0;
    end else begin
      ph_q    <= ph_next;
      pol_q   <= pol_n;
      sck     <= ph_next ^ pol_n;
      capture <= ph_next & ~ph_q;
      launch  <= ~ph_next & ph_q;
    end
  end
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import sckdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_data,
  input  logic             run,
  input  logic             idle_high,
  output logic             sck,
  output logic             launch,
  output logic             capture,
  output logic             src_sel
);
  clkcfg_t live_cfg;
  fld_t    wrap_val, hi_val;
  logic    act_q, at_wrap, ph_next, cfg_open;
  logic    unused_rsvd;

  assign unused_rsvd = ^cfg_data[RSV_MSB:RSV_LSB];
  assign wrap_val    = wrap_of(live_cfg);
  assign hi_val      = hi_of(live_cfg, wrap_val);
  assign cfg_open    = !act_q || at_wrap;
  assign src_sel     = live_cfg.src;

  sckdiv_cfg_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_cfg(cfg_unpack(cfg_data)),
    .open_win(cfg_open), .live(live_cfg)
  );

  sckdiv_phase_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .wrap(wrap_val), .hi(hi_val),
    .act_q(act_q), .at_wrap(at_wrap), .ph_next(ph_next)
  );

  sckdiv_edge_gen u_edge (
    .clk(clk), .rst_n(rst_n), .act(act_q), .ph_next(ph_next),
    .idle_high(idle_high), .sck(sck), .launch(launch), .capture(capture)
  );
endmodule

// File: rtl/sckdiv_chk.sv
module sckdiv_chk
  import sckdiv_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    run,
  input logic    idle_high,
  input logic    sck,
  input logic    launch,
  input logic    capture,
  input logic    act_q,
  input logic    at_wrap,
  input clkcfg_t live_cfg
);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && launch));
  // R5
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (sck != $past(sck)));
  // R5
  capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && $past(act_q)) |-> (sck != $past(sck)));
  // R6
  start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> capture);
  // R7
  stop_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(at_wrap && !run));
  // R8
  cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(live_cfg) |-> $past(!act_q || at_wrap));
  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !act_q && ($past(act_q) == 1'b0) && $stable(idle_high)) |=> $stable(sck));
  // R10
  run_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && !launch && !capture) |-> $stable(sck));
endmodule

bind spi_sck_divider sckdiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .idle_high(idle_high), .sck(sck),
  .launch(launch), .capture(capture), .act_q(act_q), .at_wrap(at_wrap),
  .live_cfg(live_cfg)
);

// File: tb/test_spi_sck_divider.sv
`timescale 1ns/1ps
module test_spi_sck_divider;
  logic        clk = 1'b0;
  logic        rst_n, cfg_wr, run, idle_high;
  logic [31:0] cfg_data;
  logic        sck, launch, capture, src_sel;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  spi_sck_divider i_spi_sck_divider (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .run(run),
    .idle_high(idle_high), .sck(sck), .launch(launch), .capture(capture),
    .src_sel(src_sel)
  );

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int got, input int want);
    n_chk++;
    if (got != want) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, got, want);
    end
  endtask

  function automatic logic [31:0] mkcfg(input bit src, input int dv, input int h, input int l,
                                        input logic [12:0] junk);
    return {src, junk, dv[5:0], h[5:0], l[5:0]};
  endfunction

  // Period limit per R2, active-phase end per R3.
  function automatic int lim_of(input int l, input int dv);
    if (l > 0) return l;
    if (dv > 0) return dv;
    return 1;
  endfunction
  function automatic int act_end(input int h, input int lim);
    return (h < lim) ? h : lim - 1;
  endfunction

  task automatic expect_cyc(input int i, input int p, input int h, input bit idl,
                            input bit src, input string tag);
    int ph = i % p;
    chk({tag, " R3 sck"}, sck, (ph <= h) ? !idl : idl);
    chk({tag, " R5 capture"}, capture, ph == 0);
    chk({tag, " R5 launch"}, launch, ph == h + 1);
    chk({tag, " R9 src_sel"}, src_sel, src);
  endtask

  task automatic check_parked(input bit idl, input string tag);
    repeat (2) begin
      tick;
      chk({tag, " R7 parked sck"}, sck, idl);
      chk({tag, " R7 no capture"}, capture, 0);
      chk({tag, " R7 no launch"}, launch, 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset sck", sck, 0);
    chk("R1 reset launch", launch, 0);
    chk("R1 reset capture", capture, 0);
    chk("R1 reset src_sel", src_sel, 0);
  endtask

  task automatic t_default;
    run = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick;
      if (i == 0) chk("R6 first cycle active", sck, 1);
      expect_cyc(i, 2, 0, 1'b0, 1'b0, "R1 default");
      if (i == 4) run = 1'b0;
    end
    check_parked(1'b0, "R1 default");
  endtask

  task automatic t_idle_level;
    idle_high = 1'b1;
    tick;
    chk("R4 idle follows high", sck, 1);
    chk("R4 idle no capture", capture, 0);
    idle_high = 1'b0;
    tick;
    chk("R4 idle follows low", sck, 0);
    chk("R4 idle no launch", launch, 0);
  endtask

  task automatic run_pattern(input bit src, input int dv, input int h, input int l,
                             input logic [12:0] junk, input bit idl, input int nper,
                             input string tag);
    int lim = lim_of(l, dv);
    int he  = act_end(h, lim);
    int p   = lim + 1;
    idle_high = idl;
    cfg_wr = 1'b1;
    cfg_data = mkcfg(src, dv, h, l, junk);
    tick;
    cfg_wr = 1'b0;
    chk({tag, " R8 R9 idle write src_sel"}, src_sel, src);
    tick;
    chk({tag, " R4 idle level"}, sck, idl);
    run = 1'b1;
    for (int i = 0; i < nper * p; i++) begin
      tick;
      expect_cyc(i, p, he, idl, src, {tag, " R2"});
      if (i == (nper - 1) * p + 1) run = 1'b0;
    end
    check_parked(idl, tag);
  endtask

  task automatic run_switch(input int la, input int ha, input int lb, input int hb,
                            input int s, input string tag);
    int pa = la + 1;
    int pb = lb + 1;
    int hea = act_end(ha, la);
    int heb = act_end(hb, lb);
    int bstart = (s / pa + 1) * pa;
    int total = bstart + 2 * pb;
    idle_high = 1'b0;
    cfg_wr = 1'b1;
    cfg_data = mkcfg(1'b0, la, ha, la, 13'd0);
    tick;
    cfg_wr = 1'b0;
    tick;
    run = 1'b1;
    for (int i = 0; i < total; i++) begin
      tick;
      if (i == s + 1) cfg_wr = 1'b0;
      if (i < bstart) expect_cyc(i, pa, hea, 1'b0, 1'b0, {tag, " R8 old"});
      else            expect_cyc(i - bstart, pb, heb, 1'b0, 1'b1, {tag, " R8 new"});
      if (i == s) begin
        cfg_wr = 1'b1;
        cfg_data = mkcfg(1'b1, lb, hb, lb, 13'd0);
      end
      if (i == bstart + pb) run = 1'b0;
    end
    check_parked(1'b0, tag);
  endtask

  task automatic t_pol_midrun;
    idle_high = 1'b0;
    cfg_wr = 1'b1;
    cfg_data = mkcfg(1'b0, 3, 1, 3, 13'd0);
    tick;
    cfg_wr = 1'b0;
    tick;
    run = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick;
      expect_cyc(i, 4, 1, 1'b0, 1'b0, "R10 pol flip");
      if (i == 2) idle_high = 1'b1;
      if (i == 9) run = 1'b0;
    end
    tick;
    chk("R10 old level at stop", sck, 0);
    tick;
    chk("R10 new level after stop", sck, 1);
    chk("R10 no capture", capture, 0);
    idle_high = 1'b0;
    tick;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_data = '0; run = 1'b0; idle_high = 1'b0;
    tick; tick;
    t_reset;
    rst_n = 1'b1;
    tick;
    t_reset;
    t_default;
    t_idle_level;
    run_pattern(1'b0, 4, 1, 4, 13'd0, 1'b0, 3, "n4");
    run_pattern(1'b1, 5, 2, 5, 13'd0, 1'b1, 2, "n5 idle high");
    run_pattern(1'b0, 1, 0, 1, 13'd0, 1'b0, 3, "n1");
    run_pattern(1'b0, 3, 63, 3, 13'd0, 1'b0, 2, "R3 clamp");
    run_pattern(1'b1, 5, 2, 0, 13'd0, 1'b0, 2, "R2 low zero");
    run_pattern(1'b0, 0, 0, 0, 13'd0, 1'b0, 3, "R2 all zero");
    run_pattern(1'b0, 6, 2, 6, 13'h1fff, 1'b0, 2, "R11 reserved");
    run_switch(3, 1, 6, 2, 5, "mid write");
    run_switch(3, 1, 6, 2, 3, "wrap write");
    t_pol_midrun;
    done = 1'b1;
    finish_up;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual running expected finished");
      finish_up;
    end
  end
endmodule